// File: doc/BRIEF.md
# Signature Write Decoder

This block sits beside a processor's data-memory write port and listens for full-word stores to one programmable signature address. Test software reports state to the surrounding environment by storing words to that address. The first word of each message is a header. Its low byte holds a type code and its upper 24 bits hold a payload. Depending on the type, the header is either a complete message or it announces a fixed number of follow-up words that the decoder collects.

Each decoded item appears for one cycle on a valid-qualified output, together with its kind, its payload, a register index or CSR address, and the data word. The block also keeps a level pass flag and a level fail flag from the most recent test-result message, and a flag that shows whether the last status report named machine mode. Writes of the wrong width and headers with unknown type codes raise a one-cycle error pulse. The environment uses the outputs directly, so a core's internal state can be compared against what the running program reports about itself.

Top module: `sigwr_decoder`

## Requirements
- R1: Writes whose address differs from `sig_addr` produce no item and no error, and they leave the message state unchanged. A GPR dump that is interrupted by such writes resumes at the next register index.
- R2: A write to the signature address whose byte enables are not all four set gives `err_pulse` high for one cycle, one cycle later. It produces no item and leaves the message state unchanged.
- R3: A header with type code 0 in bits [7:0] is a core-status message. One cycle after the write, it gives one item with `item_kind`=0 and `item_payload` equal to bits [31:8] of the header.
- R4: `mmode_seen` is updated by every core-status item. It is 1 when that item's payload equals 2 (machine mode) and 0 for any other payload.
- R5: A header with type code 1 is a test-result message. It gives an item with `item_kind`=1 and the payload. A payload of 0 sets `test_pass`=1 and `test_fail`=0. Any non-zero payload sets `test_fail`=1 and `test_pass`=0. The two flags are never both high.
- R6: A header with type code 2 produces no item itself. Each of the next 32 signature words gives an item with `item_kind`=2, `item_gpr_idx` counting 0 to 31 in order, and `item_data` equal to the stored word. After the 32nd word, the next signature word is treated as a header.
- R7: A header with type code 3 produces no item itself. It takes the CSR address from header bits [19:8]. The next signature word gives an item with `item_kind`=3, that `item_csr_addr`, and the word as `item_data`. This holds even when idle cycles or writes to other addresses come in between. For example, header 0x00030403 names CSR 0x304.
- R8: A header with any type code above 3 gives `err_pulse` one cycle later and no item. The next signature word is again decoded as a header.
- R9: While `rst_n` is low, `item_valid`, `err_pulse`, `test_pass`, `test_fail` and `mmode_seen` are 0. After reset, the first signature word is decoded as a header.
- R10: Each accepted word gives its item or error exactly one clock after the write. `item_valid` is high only in that cycle, and consecutive writes give items on consecutive cycles.
- R11: Writes to an address that was the signature address before `sig_addr` changed are ignored, and writes to the new address are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sig_addr | input | 32 | Programmable signature address |
| wr_en | input | 1 | Write strobe of the monitored data port |
| wr_addr | input | 32 | Write address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables of the write |
| item_valid | output | 1 | One-cycle pulse marking a decoded item |
| item_kind | output | 2 | 0 status, 1 result, 2 GPR value, 3 CSR value |
| item_payload | output | 24 | Header payload for status and result items |
| item_gpr_idx | output | 5 | Register index for GPR items |
| item_csr_addr | output | 12 | CSR address for CSR items |
| item_data | output | 32 | Stored word carried by the item |
| err_pulse | output | 1 | One-cycle pulse for a partial write or an unknown type code |
| test_pass | output | 1 | Last test result was pass |
| test_fail | output | 1 | Last test result was fail |
| mmode_seen | output | 1 | Last status report named machine mode |

## Verification
A wrong message state shows at the ports on the next signature write. If the state is stuck in a dump, a following header comes out as a GPR or CSR item instead of a status item. If it has left a dump too early, the remaining register values are decoded as headers, which gives error pulses or stray status items. An index counter that is off by one shows on the first GPR item, and one that is wrong at the end shows on the header that follows the 32nd word. All of these appear one cycle after the offending write, so a comparison on every clock against a behavioural model finds them within one or two cycles.

// File: rtl/sigdec_pkg.sv
package sigdec_pkg;
  localparam int WORD_W    = 32;
  localparam int TYPE_W    = 8;
  localparam int PAYLOAD_W = WORD_W - TYPE_W;
  localparam int CSR_W     = 12;
  localparam int GPR_N     = 32;
  localparam int IDX_W     = $clog2(GPR_N);
  localparam int BE_W      = WORD_W / 8;
  localparam int MMODE_CODE = 2;

  localparam logic [TYPE_W-1:0] TY_STATUS = TYPE_W'(0);
  localparam logic [TYPE_W-1:0] TY_RESULT = TYPE_W'(1);
  localparam logic [TYPE_W-1:0] TY_GPR    = TYPE_W'(2);
  localparam logic [TYPE_W-1:0] TY_CSR    = TYPE_W'(3);

  typedef enum logic [1:0] {
    K_STATUS = 2'd0,
    K_RESULT = 2'd1,
    K_GPR    = 2'd2,
    K_CSR    = 2'd3
  } item_kind_e;

  typedef enum logic [1:0] {
    S_HDR = 2'd0,
    S_GPR = 2'd1,
    S_CSR = 2'd2
  } dec_state_e;

  typedef struct packed {
    logic                 vld;
    item_kind_e           kind;
    logic [PAYLOAD_W-1:0] payload;
    logic [IDX_W-1:0]     idx;
    logic [CSR_W-1:0]     csr;
    logic [WORD_W-1:0]    data;
  } item_t;
endpackage

// File: rtl/sigdec_qual.sv
module sigdec_qual #(
  parameter int AW = 32,
  parameter int BW = 4
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_be,
  input  logic [AW-1:0] cfg_addr,
  output logic          word_stb,
  output logic          part_err
);
  logic hit;

  always_comb begin
    hit      = wr_en && (wr_addr == cfg_addr);
    word_stb = hit && (&wr_be);
    part_err = hit && !(&wr_be);
  end
endmodule

// File: rtl/sigdec_fsm.sv
module sigdec_fsm
  import sigdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word,
  output item_t             item,
  output logic              unk_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GPR_N - 1);

  dec_state_e       state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [CSR_W-1:0] csr_q, csr_d;
  logic [TYPE_W-1:0]    hdr_type;
  logic [PAYLOAD_W-1:0] hdr_payload;

  always_comb begin
    hdr_type    = word[TYPE_W-1:0];
    hdr_payload = word[WORD_W-1:TYPE_W];
    state_d = state_q;
    cnt_d   = cnt_q;
    csr_d   = csr_q;
    item    = '0;
    unk_err = 1'b0;
    if (word_stb) begin
      unique case (state_q)
        S_HDR: begin
          case (hdr_type)
            TY_STATUS: begin
              item.vld     = 1'b1;
              item.kind    = K_STATUS;
              item.payload = hdr_payload;
              item.data    = word;
            end
            TY_RESULT: begin
              item.vld     = 1'b1;
              item.kind    = K_RESULT;
              item.payload = hdr_payload;
              item.data    = word;
            end
            TY_GPR: begin
              state_d = S_GPR;
              cnt_d   = '0;
            end
            TY_CSR: begin
              state_d = S_CSR;
              csr_d   = hdr_payload[CSR_W-1:0];
            end
            default: unk_err = 1'b1;
          endcase
        end
        S_GPR: begin
          item.vld  = 1'b1;
          item.kind = K_GPR;
          item.idx  = cnt_q;
          item.data = word;
          cnt_d     = cnt_q + IDX_W'(1);
          if (cnt_q == LAST_IDX) state_d = S_HDR;
        end
        S_CSR: begin
          item.vld  = 1'b1;
          item.kind = K_CSR;
          item.csr  = csr_q;
          item.data = word;
          state_d   = S_HDR;
        end
        default: state_d = S_HDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HDR;
      cnt_q   <= '0;
      csr_q   <= '0;
    end else if (word_stb) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      csr_q   <= csr_d;
    end
  end

  assert_gpr_end_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_GPR && word_stb && cnt_q == LAST_IDX) |=> (state_q == S_HDR));

  assert_csr_end_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_CSR && word_stb) |=> (state_q == S_HDR));

  assert_unknown_idle_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_HDR && word_stb && unk_err) |=> (state_q == S_HDR));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !word_stb |=> ($stable(state_q) && $stable(cnt_q)));
endmodule

// File: rtl/sigdec_out.sv
module sigdec_out
  import sigdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_ni,
  input  item_t                item,
  input  logic                 unk_err,
  input  logic                 part_err,
  output logic                 o_valid,
  output logic [1:0]           o_kind,
  output logic [PAYLOAD_W-1:0] o_payload,
  output logic [IDX_W-1:0]     o_idx,
  output logic [CSR_W-1:0]     o_csr,
  output logic [WORD_W-1:0]    o_data,
  output logic                 o_err,
  output logic                 o_pass,
  output logic                 o_fail,
  output logic                 o_mmode
);
  logic is_result, is_status;

  always_comb begin
    is_result = item.vld && (item.kind == K_RESULT);
    is_status = item.vld && (item.kind == K_STATUS);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      o_valid <= 1'b0;
      o_err   <= 1'b0;
      o_pass  <= 1'b0;
      o_fail  <= 1'b0;
      o_mmode <= 1'b0;
    end else begin
      o_valid <= item.vld;
      o_err   <= unk_err || part_err;
      if (is_result) begin
        o_pass <= (item.payload == '0);
        o_fail <= (item.payload != '0);
      end
      if (is_status) o_mmode <= (item.payload == PAYLOAD_W'(MMODE_CODE));
    end
  end

  always_ff @(posedge clk) begin
    if (item.vld) begin
      o_kind    <= item.kind;
      o_payload <= item.payload;
      o_idx     <= item.idx;
      o_csr     <= item.csr;
      o_data    <= item.data;
    end
  end

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !(o_pass && o_fail));
endmodule

// File: rtl/sigwr_decoder.sv
module sigwr_decoder
  import sigdec_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        sig_addr,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [BE_W-1:0]      wr_be,
  output logic                 item_valid,
  output logic [1:0]           item_kind,
  output logic [PAYLOAD_W-1:0] item_payload,
  output logic [IDX_W-1:0]     item_gpr_idx,
  output logic [CSR_W-1:0]     item_csr_addr,
  output logic [WORD_W-1:0]    item_data,
  output logic                 err_pulse,
  output logic                 test_pass,
  output logic                 test_fail,
  output logic                 mmode_seen
);
  logic  rst_meta, rst_sync_n;
  logic  word_stb, part_err, unk_err;
  item_t item;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sigdec_qual #(.AW(AW), .BW(BE_W)) u_qual (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_be    (wr_be),
    .cfg_addr (sig_addr),
    .word_stb (word_stb),
    .part_err (part_err)
  );

  sigdec_fsm u_fsm (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .word_stb (word_stb),
    .word     (wr_data),
    .item     (item),
    .unk_err  (unk_err)
  );

  sigdec_out u_out (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .item      (item),
    .unk_err   (unk_err),
    .part_err  (part_err),
    .o_valid   (item_valid),
    .o_kind    (item_kind),
    .o_payload (item_payload),
    .o_idx     (item_gpr_idx),
    .o_csr     (item_csr_addr),
    .o_data    (item_data),
    .o_err     (err_pulse),
    .o_pass    (test_pass),
    .o_fail    (test_fail),
    .o_mmode   (mmode_seen)
  );

  assert_partial_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    part_err |=> (err_pulse && !item_valid));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(word_stb || part_err) |=> (!item_valid && !err_pulse));
endmodule

// File: tb/sigwr_decoder_tb.sv
`timescale 1ns/1ps
module sigwr_decoder_tb;
  localparam int WD_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sig_addr = 32'h8FFF_FFFC;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        item_valid, err_pulse, test_pass, test_fail, mmode_seen;
  logic [1:0]  item_kind;
  logic [23:0] item_payload;
  logic [4:0]  item_gpr_idx;
  logic [11:0] item_csr_addr;
  logic [31:0] item_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural model state
  int          m_state = 0;
  int          m_cnt = 0;
  logic [11:0] m_csr = '0;
  logic        m_pass = 0, m_fail = 0, m_mm = 0;

  always #4 clk = ~clk;

  sigwr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .sig_addr(sig_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .item_valid(item_valid), .item_kind(item_kind), .item_payload(item_payload),
    .item_gpr_idx(item_gpr_idx), .item_csr_addr(item_csr_addr), .item_data(item_data),
    .err_pulse(err_pulse), .test_pass(test_pass), .test_fail(test_fail),
    .mmode_seen(mmode_seen)
  );

  task automatic step(input logic en, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, input string tag);
    logic e_v = 0, e_err = 0;
    int   e_kind = 0;
    logic [23:0] e_pl = '0;
    int   e_idx = 0;
    logic [11:0] e_csr = '0;
    logic [31:0] e_data = d;
    bit ok;
    if (en && a == sig_addr) begin
      if (be != 4'hF) e_err = 1;
      else if (m_state == 0) begin
        case (d[7:0])
          8'd0: begin e_v = 1; e_kind = 0; e_pl = d[31:8]; m_mm = (d[31:8] == 24'd2); end
          8'd1: begin e_v = 1; e_kind = 1; e_pl = d[31:8];
                      m_pass = (d[31:8] == 0); m_fail = (d[31:8] != 0); end
          8'd2: begin m_state = 1; m_cnt = 0; end
          8'd3: begin m_state = 2; m_csr = d[19:8]; end
          default: e_err = 1;
        endcase
      end else if (m_state == 1) begin
        e_v = 1; e_kind = 2; e_idx = m_cnt; m_cnt++;
        if (m_cnt == 32) m_state = 0;
      end else begin
        e_v = 1; e_kind = 3; e_csr = m_csr; m_state = 0;
      end
    end
    wr_en = en; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0;
    ok = (item_valid === e_v) && (err_pulse === e_err) && (test_pass === m_pass) &&
         (test_fail === m_fail) && (mmode_seen === m_mm);
    if (ok && e_v) begin
      ok = (int'(item_kind) == e_kind);
      if (e_kind <= 1) ok = ok && (item_payload === e_pl);
      if (e_kind == 2) ok = ok && (int'(item_gpr_idx) == e_idx) && (item_data === e_data);
      if (e_kind == 3) ok = ok && (item_csr_addr === e_csr) && (item_data === e_data);
    end
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual v=%b e=%b k=%0d pl=%h idx=%0d csr=%h d=%h p=%b f=%b m=%b expected v=%b e=%b k=%0d pl=%h idx=%0d csr=%h d=%h p=%b f=%b m=%b",
               tag, item_valid, err_pulse, item_kind, item_payload, item_gpr_idx, item_csr_addr,
               item_data, test_pass, test_fail, mmode_seen,
               e_v, e_err, e_kind, e_pl, e_idx, e_csr, e_data, m_pass, m_fail, m_mm);
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'h0, 32'h0, 4'h0, tag);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0;
    m_state = 0; m_cnt = 0; m_pass = 0; m_fail = 0; m_mm = 0;
    idle(tag);
    idle(tag);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) idle(tag);
  endtask

  initial begin
    #(WD_CYC * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10: watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset("R9 reset state");
    // status messages, back to back
    step(1, sig_addr, 32'h0000_0200, 4'hF, "R3 R4 status machine mode");
    step(1, sig_addr, 32'h0000_0500, 4'hF, "R3 R4 status other code");
    step(1, sig_addr, 32'h0000_0200, 4'hF, "R4 machine mode again");
    // test results
    step(1, sig_addr, 32'h0000_0001, 4'hF, "R5 pass");
    step(1, sig_addr, 32'h0000_0101, 4'hF, "R5 fail");
    idle("R5 flags hold");
    step(1, sig_addr, 32'h0000_0001, 4'hF, "R5 pass after fail");
    // other address and partial write
    step(1, 32'h8000_0000, 32'h0000_0101, 4'hF, "R1 other address");
    step(1, sig_addr, 32'h0000_0101, 4'h3, "R2 partial write");
    step(1, sig_addr, 32'h0000_0300, 4'hF, "R2 header after partial");
    // GPR dump with interruptions
    step(1, sig_addr, 32'h0000_0002, 4'hF, "R6 gpr header");
    for (int i = 0; i < 32; i++) begin
      if (i == 5) step(1, 32'h1000_0000, 32'hDEAD_0000, 4'hF, "R1 foreign write mid dump");
      if (i == 9) step(1, sig_addr, 32'h0000_0000, 4'h1, "R2 partial mid dump");
      step(1, sig_addr, 32'hA5A5_0000 + 32'(i * 3), 4'hF, "R6 gpr value");
    end
    step(1, sig_addr, 32'h0000_0700, 4'hF, "R6 R10 header right after dump");
    // CSR dumps
    step(1, sig_addr, 32'h0003_0403, 4'hF, "R7 csr header");
    step(1, sig_addr, 32'h1234_5678, 4'hF, "R7 csr value");
    step(1, sig_addr, 32'h000F_FF03, 4'hF, "R7 csr header 2");
    idle("R7 gap");
    step(1, 32'h0000_0040, 32'h0000_0001, 4'hF, "R7 foreign write in gap");
    idle("R7 gap");
    step(1, sig_addr, 32'hCAFE_F00D, 4'hF, "R7 csr value after gap");
    // unknown type
    step(1, sig_addr, 32'h0000_0007, 4'hF, "R8 unknown type");
    step(1, sig_addr, 32'h0000_0100, 4'hF, "R8 next is header");
    step(1, sig_addr, 32'h0000_00FF, 4'hF, "R8 unknown type FF");
    // address change
    sig_addr = 32'h4000_0010;
    step(1, 32'h8FFF_FFFC, 32'h0000_0001, 4'hF, "R11 old address ignored");
    step(1, 32'h4000_0010, 32'h0000_0201, 4'hF, "R11 new address fail");
    // reset mid dump
    step(1, sig_addr, 32'h0000_0002, 4'hF, "R6 gpr header before reset");
    step(1, sig_addr, 32'h0000_1111, 4'hF, "R6 gpr value before reset");
    do_reset("R9 reset mid dump");
    step(1, sig_addr, 32'h0000_0001, 4'hF, "R9 header after reset");
    idle("R10 single cycle pulse");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule